// File: doc/BRIEF.md
# Counter Overflow Flag Set Register

This block keeps the sticky overflow status of a performance-monitoring unit. It holds one flag for the cycle counter and one flag for each implemented event counter, up to 31. The counters report wrap events as two carry pulses per counter, one for the low 32 bits and one for the full 64 bits. For each counter class, a long-counter control picks the pulse that counts as an overflow. A software write port sets flags with write-one-to-set semantics. A second port, driven by a write-one-to-clear alias, clears them. The 64-bit status word is returned on a combinational read port.

Software only sees a window of the event flags. When a hypervisor is active and the access comes from kernel or user privilege, the window ends at the hypervisor's partition count. In every other case it ends at the number of implemented counters. Flags outside the window keep their stored value. Software reads them as zero and its writes and clears do not touch them. The complete stored flag vector also drives an interrupt-request output, which feeds a separate interrupt-enable stage.

Top module: `pmu_ovf_flags`

## Requirements
- R1: Read bits [63:32] are always zero, and the write and clear data in those bits has no effect.
- R2: Bit 31 is the cycle-counter flag, and bit n (n < NUM_EVT) is the flag of event counter n. Bits NUM_EVT to 30 are never set and always read zero.
- R3: With `sw_set_en` high, each visible bit written as 1 is set one cycle later. Bits written as 0 keep their value.
- R4: A set flag stays set until a `sw_clr_en` cycle carries a 1 in that visible bit position. The flag is clear from the following cycle on. With no set source, no flag becomes set.
- R5: When `cyc_long` is 0, `cyc_wrap32` sets bit 31 and `cyc_wrap64` is ignored. When `cyc_long` is 1, the roles of the two pulses are swapped.
- R6: Event counter n is in the reserved range when `hyp_active` is 1 and n >= `hyp_part`. Reserved counters use `evt_long_hi` and all others use `evt_long_lo`. A long value of 0 selects `evt_wrap32[n]` and a value of 1 selects `evt_wrap64[n]`.
- R7: The visible limit L is min(`hyp_part`, NUM_EVT) when `hyp_active` and `low_priv` are both 1, and NUM_EVT otherwise. Event bits at or above L read as zero, and software set and clear leave them unchanged. Counter overflows still set them.
- R8: A counter overflow and a software set that land on bits in the same cycle set every bit that either one names.
- R9: When a set (from software or a counter) and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: `irq_req` is the stored flag vector, visibility masking not applied, and it is updated on the same edge as the flags.
- R11: A synchronous reset (`rst_n` low at a clock edge) clears every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_set_en | input | 1 | Software write-one-to-set strobe |
| sw_set_data | input | 64 | Write-one-to-set data |
| sw_clr_en | input | 1 | Write-one-to-clear strobe from the clear alias |
| sw_clr_data | input | 64 | Write-one-to-clear data |
| cyc_wrap32 | input | 1 | Cycle counter carried out of bit 31 |
| cyc_wrap64 | input | 1 | Cycle counter carried out of bit 63 |
| cyc_long | input | 1 | Cycle counter overflows at 64 bits when 1 |
| evt_wrap32 | input | NUM_EVT | Per event counter carry out of bit 31 |
| evt_wrap64 | input | NUM_EVT | Per event counter carry out of bit 63 |
| evt_long_lo | input | 1 | 64-bit overflow for counters outside the reserved range |
| evt_long_hi | input | 1 | 64-bit overflow for counters in the hypervisor-reserved range |
| hyp_active | input | 1 | Hypervisor level implemented and enabled |
| low_priv | input | 1 | Access comes from kernel or user privilege |
| hyp_part | input | 5 | Hypervisor counter-partition count |
| rd_data | output | 64 | Status word as software sees it |
| irq_req | output | 32 | Stored flags toward the interrupt-enable stage |

## Verification
The bench sweeps every partition value from 0 to 7 against six implemented counters. It covers both hypervisor states and both privilege levels, and it includes partition values above the counter count, which a design without clamping would turn into phantom visible bits. For each counter and each long-control pair it fires each carry alone, which exposes a design that uses the wrong range enable at the partition edge or listens to the unselected carry. It also writes and clears from the limited context and then reads back from the full context. A design that masked only the read path, or that masked the stored flags as well, fails that readback. The set-against-clear and counter-against-write collisions are also driven, so a design that lets a clear win or drops one of two set sources is caught.

// File: rtl/ovf_flags_pkg.sv
package ovf_flags_pkg;

    localparam int FLAG_W    = 32;
    localparam int REG_W     = 64;
    localparam int CYC_POS   = 31;
    localparam int EVT_SLOTS = 31;
    localparam int PART_W    = 5;

    typedef logic [FLAG_W-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
    } ovf_state_t;

    // Bits that physically exist: cycle flag plus the implemented event flags.
    function automatic flag_vec_t impl_mask(input int num_evt);
        flag_vec_t m;
        m = '0;
        for (int i = 0; i < EVT_SLOTS; i++) begin
            if (i < num_evt) m[i] = 1'b1;
        end
        m[CYC_POS] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ovf_select.sv
module ovf_select
    import ovf_flags_pkg::*;
#(
    parameter int NUM_EVT = 31
) (
    input  logic                 cyc_wrap32,
    input  logic                 cyc_wrap64,
    input  logic                 cyc_long,
    input  logic [NUM_EVT-1:0]   evt_wrap32,
    input  logic [NUM_EVT-1:0]   evt_wrap64,
    input  logic                 evt_long_lo,
    input  logic                 evt_long_hi,
    input  logic                 hyp_active,
    input  logic [PART_W-1:0]    hyp_part,
    output flag_vec_t            hit
);

    // Cycle counter: the long control picks which carry counts.
    assign hit[CYC_POS] = cyc_long ? cyc_wrap64 : cyc_wrap32;

    for (genvar n = 0; n < EVT_SLOTS; n++) begin : g_slot
        if (n < NUM_EVT) begin : g_impl
            logic reserved;
            logic use_long;
            assign reserved = hyp_active && (PART_W'(n) >= hyp_part);
            assign use_long = reserved ? evt_long_hi : evt_long_lo;
            assign hit[n]   = use_long ? evt_wrap64[n] : evt_wrap32[n];
        end else begin : g_absent
            assign hit[n] = 1'b0;
        end
    end

endmodule

// File: rtl/access_window.sv
module access_window
    import ovf_flags_pkg::*;
#(
    parameter int NUM_EVT = 31
) (
    input  logic              hyp_active,
    input  logic              low_priv,
    input  logic [PART_W-1:0] hyp_part,
    output flag_vec_t         vis_mask
);

    localparam logic [PART_W:0] IMPL_CNT = (PART_W+1)'(NUM_EVT);

    logic [PART_W:0] part_clamped;
    logic [PART_W:0] limit;

    always_comb begin
        part_clamped = ({1'b0, hyp_part} > IMPL_CNT) ? IMPL_CNT : {1'b0, hyp_part};
        limit        = (hyp_active && low_priv) ? part_clamped : IMPL_CNT;
    end

    for (genvar n = 0; n < EVT_SLOTS; n++) begin : g_vis
        if (n < NUM_EVT) begin : g_impl
            assign vis_mask[n] = ((PART_W+1)'(n) < limit);
        end else begin : g_absent
            assign vis_mask[n] = 1'b0;
        end
    end

    // Cycle flag is visible in every context.
    assign vis_mask[CYC_POS] = 1'b1;

endmodule

// File: rtl/pmu_ovf_flags.sv
module pmu_ovf_flags
    import ovf_flags_pkg::*;
#(
    parameter int NUM_EVT = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_set_en,
    input  logic [63:0]          sw_set_data,
    input  logic                 sw_clr_en,
    input  logic [63:0]          sw_clr_data,
    input  logic                 cyc_wrap32,
    input  logic                 cyc_wrap64,
    input  logic                 cyc_long,
    input  logic [NUM_EVT-1:0]   evt_wrap32,
    input  logic [NUM_EVT-1:0]   evt_wrap64,
    input  logic                 evt_long_lo,
    input  logic                 evt_long_hi,
    input  logic                 hyp_active,
    input  logic                 low_priv,
    input  logic [4:0]           hyp_part,
    output logic [63:0]          rd_data,
    output logic [31:0]          irq_req
);

    localparam flag_vec_t IMPL = impl_mask(NUM_EVT);

    ovf_state_t st_d;
    ovf_state_t st_q;
    flag_vec_t  hw_hit;
    flag_vec_t  vis_mask;
    flag_vec_t  set_v;
    flag_vec_t  clr_v;
    logic       unused_hi;

    // Upper halves of the write data are architecturally ignored.
    assign unused_hi = ^{sw_set_data[REG_W-1:FLAG_W], sw_clr_data[REG_W-1:FLAG_W]};

    ovf_select #(.NUM_EVT(NUM_EVT)) u_select (
        .cyc_wrap32  (cyc_wrap32),
        .cyc_wrap64  (cyc_wrap64),
        .cyc_long    (cyc_long),
        .evt_wrap32  (evt_wrap32),
        .evt_wrap64  (evt_wrap64),
        .evt_long_lo (evt_long_lo),
        .evt_long_hi (evt_long_hi),
        .hyp_active  (hyp_active),
        .hyp_part    (hyp_part),
        .hit         (hw_hit)
    );

    access_window #(.NUM_EVT(NUM_EVT)) u_window (
        .hyp_active (hyp_active),
        .low_priv   (low_priv),
        .hyp_part   (hyp_part),
        .vis_mask   (vis_mask)
    );

    always_comb begin
        set_v = hw_hit;
        if (sw_set_en) set_v = set_v | (sw_set_data[FLAG_W-1:0] & vis_mask);
        clr_v = '0;
        if (sw_clr_en) clr_v = sw_clr_data[FLAG_W-1:0] & vis_mask;
        // Clear first, then set: a colliding set wins.
        st_d.flags = ((st_q.flags & ~clr_v) | set_v) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = {{(REG_W-FLAG_W){1'b0}}, st_q.flags & vis_mask};
    assign irq_req = st_q.flags;

endmodule

// File: rtl/pmu_ovf_flags_chk.sv
module pmu_ovf_flags_chk #(
    parameter int NUM_EVT = 31
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sw_set_en,
    input logic [63:0]        sw_set_data,
    input logic               sw_clr_en,
    input logic [63:0]        sw_clr_data,
    input logic               cyc_wrap32,
    input logic               cyc_wrap64,
    input logic               cyc_long,
    input logic [NUM_EVT-1:0] evt_wrap32,
    input logic [NUM_EVT-1:0] evt_wrap64,
    input logic [63:0]        rd_data,
    input logic [31:0]        irq_req
);

    assert_sw_set_cyc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set_en && sw_set_data[31]) |=> irq_req[31]);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_clr_en |=> ((irq_req & $past(irq_req)) == $past(irq_req)));

    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_set_en && !cyc_wrap32 && !cyc_wrap64 && (evt_wrap32 == '0) && (evt_wrap64 == '0))
        |=> ((irq_req & ~$past(irq_req)) == 32'h0));

    assert_cyc_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_long && cyc_wrap32) |=> irq_req[31]);

    assert_cyc_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_long && cyc_wrap64) |=> irq_req[31]);

    assert_read_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data[31:0] & ~irq_req) == 32'h0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set_en && sw_clr_en && sw_set_data[31] && sw_clr_data[31]) |=> irq_req[31]);

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (irq_req == 32'h0));

endmodule

bind pmu_ovf_flags pmu_ovf_flags_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_set_en   (sw_set_en),
    .sw_set_data (sw_set_data),
    .sw_clr_en   (sw_clr_en),
    .sw_clr_data (sw_clr_data),
    .cyc_wrap32  (cyc_wrap32),
    .cyc_wrap64  (cyc_wrap64),
    .cyc_long    (cyc_long),
    .evt_wrap32  (evt_wrap32),
    .evt_wrap64  (evt_wrap64),
    .rd_data     (rd_data),
    .irq_req     (irq_req)
);

// File: tb/pmu_ovf_flags_tb.sv
module pmu_ovf_flags_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 6;
    localparam logic [31:0] IMPL = 32'h8000_0000 | ((32'h1 << NE) - 1);

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_set_en;
    logic [63:0] sw_set_data;
    logic        sw_clr_en;
    logic [63:0] sw_clr_data;
    logic        cyc_wrap32, cyc_wrap64, cyc_long;
    logic [NE-1:0] evt_wrap32, evt_wrap64;
    logic        evt_long_lo, evt_long_hi;
    logic        hyp_active, low_priv;
    logic [4:0]  hyp_part;
    logic [63:0] rd_data;
    logic [31:0] irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] exp_f;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_ovf_flags #(.NUM_EVT(NE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sw_set_en(sw_set_en), .sw_set_data(sw_set_data),
        .sw_clr_en(sw_clr_en), .sw_clr_data(sw_clr_data),
        .cyc_wrap32(cyc_wrap32), .cyc_wrap64(cyc_wrap64), .cyc_long(cyc_long),
        .evt_wrap32(evt_wrap32), .evt_wrap64(evt_wrap64),
        .evt_long_lo(evt_long_lo), .evt_long_hi(evt_long_hi),
        .hyp_active(hyp_active), .low_priv(low_priv), .hyp_part(hyp_part),
        .rd_data(rd_data), .irq_req(irq_req)
    );

    function automatic logic [31:0] f_vis();
        int lim;
        logic [31:0] m;
        lim = NE;
        if (hyp_active && low_priv) lim = (int'(hyp_part) > NE) ? NE : int'(hyp_part);
        m = 32'h8000_0000;
        for (int i = 0; i < lim; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] f_hit();
        logic [31:0] h;
        h = '0;
        for (int n = 0; n < NE; n++) begin
            bit lng;
            lng = (hyp_active && n >= int'(hyp_part)) ? evt_long_hi : evt_long_lo;
            h[n] = lng ? evt_wrap64[n] : evt_wrap32[n];
        end
        h[31] = cyc_long ? cyc_wrap64 : cyc_wrap32;
        return h;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic idle_inputs();
        sw_set_en = 0; sw_set_data = '0; sw_clr_en = 0; sw_clr_data = '0;
        cyc_wrap32 = 0; cyc_wrap64 = 0; evt_wrap32 = '0; evt_wrap64 = '0;
    endtask

    // One clock: model the next flags, clock, then compare at the falling edge.
    task automatic tick(input string tag);
        logic [31:0] vis, setv, clrv, nxt;
        vis  = f_vis();
        setv = f_hit() | (sw_set_en ? (sw_set_data[31:0] & vis) : 32'h0);
        clrv = sw_clr_en ? (sw_clr_data[31:0] & vis) : 32'h0;
        nxt  = ((exp_f & ~clrv) | setv) & IMPL;
        @(posedge clk);
        exp_f = nxt;
        @(negedge clk);
        chk({tag, " rd"}, rd_data, {32'h0, exp_f & f_vis()});
        chk({tag, " irq"}, {32'h0, irq_req}, {32'h0, exp_f});
        idle_inputs();
    endtask

    task automatic peek(input string tag);
        #1;
        chk(tag, rd_data, {32'h0, exp_f & f_vis()});
    endtask

    task automatic clear_all_full();
        hyp_active = 0; low_priv = 0;
        sw_clr_en = 1; sw_clr_data = '1;
        tick("R4 clear all");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        cyc_long = 0; evt_long_lo = 0; evt_long_hi = 0;
        hyp_active = 0; low_priv = 0; hyp_part = 5'd0;
        exp_f = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk("R11 reset irq", {32'h0, irq_req}, 64'h0);
        chk("R11 reset rd", rd_data, 64'h0);

        // R1 R2 R3: all-ones write from the full context
        sw_set_en = 1; sw_set_data = '1;
        tick("R2/R3 write ones");
        chk("R1 upper zero", {32'h0, rd_data[63:32]}, 64'h0);
        chk("R2 layout", rd_data, {32'h0, IMPL});

        repeat (3) tick("R4 sticky idle");
        sw_set_en = 1; sw_set_data = 64'hFFFF_FFFF_0000_0000;
        tick("R1/R3 zero low write");
        sw_clr_en = 1; sw_clr_data = 64'h4;
        tick("R4 clear bit2");
        sw_clr_en = 1; sw_clr_data = 64'hFFFF_FFFF_0000_0000;
        tick("R1 upper clear ignored");
        clear_all_full();
        sw_set_en = 1; sw_set_data = 64'h0000_0001_0000_0000;
        tick("R1 upper write ignored");

        // R5: cycle-counter width select
        for (int cl = 0; cl < 2; cl++) begin
            for (int k = 0; k < 2; k++) begin
                cyc_long = cl[0];
                if (k == 1) cyc_wrap64 = 1; else cyc_wrap32 = 1;
                tick("R5 cycle wrap");
                clear_all_full();
            end
        end
        cyc_long = 0;

        // R6: event width select per range, swept over partition values
        for (int he = 0; he < 2; he++)
            for (int part = 0; part < 8; part++)
                for (int lh = 0; lh < 4; lh++)
                    for (int n = 0; n < NE; n++)
                        for (int k = 0; k < 2; k++) begin
                            hyp_active = he[0]; low_priv = 0; hyp_part = 5'(part);
                            evt_long_lo = lh[0]; evt_long_hi = lh[1];
                            if (k == 1) evt_wrap64[n] = 1'b1; else evt_wrap32[n] = 1'b1;
                            tick("R6 event wrap");
                            clear_all_full();
                        end
        evt_long_lo = 0; evt_long_hi = 0;

        // R7 R10: visibility window, swept over context and partition
        for (int he = 0; he < 2; he++)
            for (int lp = 0; lp < 2; lp++)
                for (int part = 0; part < 8; part++) begin
                    clear_all_full();
                    hyp_active = he[0]; low_priv = lp[0]; hyp_part = 5'(part);
                    sw_set_en = 1; sw_set_data = '1;
                    tick("R7 masked write");
                    hyp_active = 0; low_priv = 0;
                    peek("R7 hidden bits unwritten");
                    sw_set_en = 1; sw_set_data = '1;
                    tick("R7 full set");
                    hyp_active = he[0]; low_priv = lp[0];
                    peek("R7 masked read");
                    sw_clr_en = 1; sw_clr_data = '1;
                    tick("R7 masked clear");
                    tick("R10 irq keeps hidden flags");
                    hyp_active = 0; low_priv = 0;
                    peek("R7 hidden bits kept");
                end
        hyp_part = 5'd0;

        // R8: counter overflow and software set together
        clear_all_full();
        evt_wrap32[2] = 1; sw_set_en = 1; sw_set_data = 64'h14;
        tick("R8 same bit");
        evt_wrap32[1] = 1; sw_set_en = 1; sw_set_data = 64'h1;
        tick("R8 different bits");

        // R9: set and clear collide
        clear_all_full();
        sw_set_en = 1; sw_set_data = 64'h1;
        tick("R9 prep");
        sw_set_en = 1; sw_set_data = 64'h8000_0002;
        sw_clr_en = 1; sw_clr_data = 64'h8000_0003;
        tick("R9 sw set beats clear");
        chk("R9 result", {32'h0, irq_req}, 64'h8000_0002);
        cyc_wrap32 = 1; evt_wrap32[3] = 1; sw_clr_en = 1; sw_clr_data = '1;
        tick("R9 hw set beats clear");
        chk("R9 hw result", {32'h0, irq_req}, 64'h8000_0008);

        // R11: reset mid-run clears
        sw_set_en = 1; sw_set_data = '1;
        tick("R3 refill");
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        exp_f = '0;
        chk("R11 mid-run reset", {32'h0, irq_req}, 64'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule